// File: doc/BRIEF.md
# Triggered DMA Channel Engine

This block is one DMA channel. It copies data from a source address to a destination address each time a chosen peripheral trigger fires. Software sets up the channel through a small register write port. The settings are a trigger select, the burst and transfer sizes written as N-1, and signed address steps for two levels. Source and destination addresses are written to shadow registers. When a new transfer begins, the channel copies these shadow values into its working addresses.

One transfer is made of one or more bursts. A burst is made of one or more moves, and each move is either 16 or 32 bits wide. Each move uses a read cycle on the memory master port, one cycle to capture the read data, and then a write cycle. The port carries at most one access per cycle. Trigger pulses are held in a single pending flag. If a pulse arrives while the flag is still set, the overflow flag is raised. The channel can pulse an interrupt when a transfer starts or when it ends. In continuous mode it re-arms after each transfer; otherwise it stops.

Top module: `dma_chan_engine`

## Requirements
- R1: After the synchronous reset, and after a hard reset, all outputs are low. A hard reset is bit 1 written to register 0. It clears the pending and overflow flags, stops the channel and clears every configuration register.
- R2: Register map (3-bit address):
  - 0, control (write only): bit 0 starts the channel; bit 2 clears the pending trigger flag; bit 3 clears the overflow flag.
  - 1, mode: bits 4:0 trigger select; bit 5 trigger enable; bit 6 one-shot; bit 7 continuous; bit 8 32-bit moves; bit 9 interrupt at end (0 means at start); bit 10 interrupt enable.
  - 2, burst size.
  - 3, burst steps: source in bits 15:0, destination in bits 31:16.
  - 4, transfer size.
  - 5, transfer steps, with the same layout as register 3.
  - 6, source shadow address.
  - 7, destination shadow address.
- R3: The burst size field holds the number of 16-bit words per burst minus one. A burst makes size+1 moves in 16-bit mode and (size>>1)+1 moves in 32-bit mode.
- R4: The transfer size field holds the number of bursts minus one. The working addresses are loaded from the shadows only when a transfer starts, so a shadow written mid-transfer affects only the next transfer.
- R5: After each move inside a burst, the burst steps are added to the addresses. Between two bursts, the transfer steps are added instead. Steps are 16-bit two's complement.
- R6: With one-shot off, each accepted trigger moves exactly one burst. With one-shot on, one trigger moves the whole transfer.
- R7: When a transfer completes, a continuous channel stays busy and waits for the next trigger. A non-continuous channel stops, and busy goes low.
- R8: When the interrupt is enabled, irq pulses for one cycle.
  - In start mode, the pulse comes in the same cycle as the first read of the transfer.
  - In end mode, the pulse comes in the cycle after the transfer's last write.
  - When the interrupt is disabled, irq never pulses.
- R9: A trigger counts only when the enable bit is set and the pulse is on the selected input. Any other pulse leaves the flags unchanged and causes no memory access.
- R10: A counted trigger sets the pending flag, even while the channel is stopped. A trigger that arrives while the flag is set and is not being taken raises the sticky overflow flag. Each flag clears only through its own clear bit or a reset.
- R11: A move is one read cycle, one capture cycle, then one write cycle. The write carries the data read two cycles earlier. mem_rd and mem_wr are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| trig_in | input | NTRIG | Peripheral trigger pulses |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_rd |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wide | output | 1 | High when moves are 32 bits |
| mem_addr | output | AW | Access address |
| mem_wdata | output | 32 | Write data |
| irq | output | 1 | Channel interrupt pulse |
| busy | output | 1 | Channel running |
| trig_flag | output | 1 | Pending trigger latched |
| ovf_flag | output | 1 | Trigger overflow seen |

## Verification
A bad move or burst counter makes the count of writes in a burst wrong. It also shifts the end-of-transfer interrupt, and both show up within one burst. A wrong step or a missed shadow load sends a write to the wrong address, or with data from the wrong source word. The bench compares every logged write against an address sequence it computes itself, so such a fault shows on the first affected move. Flag faults are read directly on trig_flag and ovf_flag, a cycle after the pulse that caused them.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_MODE  = 3'd1,
    RA_BSIZE = 3'd2,
    RA_BSTEP = 3'd3,
    RA_TSIZE = 3'd4,
    RA_TSTEP = 3'd5,
    RA_SRC   = 3'd6,
    RA_DST   = 3'd7
  } reg_addr_e;

  // field order matches the mode register bit positions (bit 10 down to 0)
  typedef struct packed {
    logic       inten;
    logic       int_at_end;
    logic       wide;
    logic       cont;
    logic       oneshot;
    logic       trig_en;
    logic [4:0] sel;
  } mode_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ARM,
    S_RD,
    S_CAP,
    S_WR
  } seq_state_e;

  localparam int CTRL_RUN     = 0;
  localparam int CTRL_HRST    = 1;
  localparam int CTRL_CLRTRIG = 2;
  localparam int CTRL_CLROVF  = 3;
  localparam int MODE_W       = 11;

endpackage

// File: rtl/dmach_regs.sv
module dmach_regs
  import dmach_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [2:0]    addr,
  input  logic [31:0]   wdata,
  output mode_t         mode,
  output logic [CW-1:0] bsize,
  output logic [CW-1:0] tsize,
  output logic [SW-1:0] bstep_s,
  output logic [SW-1:0] bstep_d,
  output logic [SW-1:0] tstep_s,
  output logic [SW-1:0] tstep_d,
  output logic [AW-1:0] src_sh,
  output logic [AW-1:0] dst_sh,
  output logic          go,
  output logic          clr_trig,
  output logic          clr_ovf
);

  reg_addr_e ra;
  logic      ctrl_wr;

  assign ra       = reg_addr_e'(addr);
  assign ctrl_wr  = we && (ra == RA_CTRL);
  assign go       = ctrl_wr && wdata[CTRL_RUN];
  assign clr_trig = ctrl_wr && wdata[CTRL_CLRTRIG];
  assign clr_ovf  = ctrl_wr && wdata[CTRL_CLROVF];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= '0;
      bsize   <= '0;
      tsize   <= '0;
      bstep_s <= '0;
      bstep_d <= '0;
      tstep_s <= '0;
      tstep_d <= '0;
      src_sh  <= '0;
      dst_sh  <= '0;
    end else if (we) begin
      case (ra)
        RA_MODE:  mode    <= mode_t'(wdata[MODE_W-1:0]);
        RA_BSIZE: bsize   <= wdata[CW-1:0];
        RA_BSTEP: begin
          bstep_s <= wdata[SW-1:0];
          bstep_d <= wdata[16 +: SW];
        end
        RA_TSIZE: tsize   <= wdata[CW-1:0];
        RA_TSTEP: begin
          tstep_s <= wdata[SW-1:0];
          tstep_d <= wdata[16 +: SW];
        end
        RA_SRC:   src_sh  <= wdata[AW-1:0];
        RA_DST:   dst_sh  <= wdata[AW-1:0];
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/dmach_trig.sv
module dmach_trig #(
  parameter int NTRIG = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NTRIG-1:0] trig_in,
  input  logic [4:0]       sel,
  input  logic             en,
  input  logic             take,
  input  logic             clr_trig,
  input  logic             clr_ovf,
  output logic             pend,
  output logic             ovf
);

  logic [NTRIG-1:0] match;
  logic             hit;

  // one comparator per input; select values past NTRIG-1 match nothing
  for (genvar i = 0; i < NTRIG; i++) begin : g_match
    assign match[i] = trig_in[i] && (sel == 5'(i));
  end

  assign hit = en && (|match);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      if (hit)
        pend <= 1'b1;
      else if (take || clr_trig)
        pend <= 1'b0;

      if (hit && pend && !take)
        ovf <= 1'b1;
      else if (clr_ovf)
        ovf <= 1'b0;
    end
  end

endmodule

// File: rtl/dmach_seq.sv
module dmach_seq
  import dmach_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          pend,
  input  logic          inten,
  input  logic          int_at_end,
  input  logic          wide,
  input  logic          cont,
  input  logic          oneshot,
  input  logic [CW-1:0] bsize,
  input  logic [CW-1:0] tsize,
  input  logic [SW-1:0] bstep_s,
  input  logic [SW-1:0] bstep_d,
  input  logic [SW-1:0] tstep_s,
  input  logic [SW-1:0] tstep_d,
  input  logic [AW-1:0] src_sh,
  input  logic [AW-1:0] dst_sh,
  input  logic [31:0]   mem_rdata,
  output logic          take,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic          irq,
  output logic          busy
);

  seq_state_e    st;
  logic [AW-1:0] src_a, dst_a;
  logic [CW-1:0] mv_left, bu_left;
  logic          first;
  logic [CW-1:0] moves_m1;
  logic [AW-1:0] src_bn, dst_bn, src_tn, dst_tn;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] a, input logic [SW-1:0] s);
    return a + AW'($signed(s));
  endfunction

  assign moves_m1 = wide ? (bsize >> 1) : bsize;
  assign src_bn   = adv(src_a, bstep_s);
  assign dst_bn   = adv(dst_a, bstep_d);
  assign src_tn   = adv(src_a, tstep_s);
  assign dst_tn   = adv(dst_a, tstep_d);
  assign take     = (st == S_ARM) && pend;
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      src_a     <= '0;
      dst_a     <= '0;
      mv_left   <= '0;
      bu_left   <= '0;
      first     <= 1'b0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (st)
        S_IDLE: begin
          if (go) begin
            st    <= S_ARM;
            first <= 1'b1;
          end
        end
        S_ARM: begin
          if (pend) begin
            mv_left <= moves_m1;
            mem_rd  <= 1'b1;
            st      <= S_RD;
            if (first) begin
              src_a    <= src_sh;
              dst_a    <= dst_sh;
              mem_addr <= src_sh;
              bu_left  <= tsize;
              first    <= 1'b0;
              if (inten && !int_at_end) irq <= 1'b1;
            end else begin
              mem_addr <= src_a;
            end
          end
        end
        S_RD: begin
          mem_rd <= 1'b0;
          st     <= S_CAP;
        end
        S_CAP: begin
          mem_wdata <= mem_rdata;
          mem_wr    <= 1'b1;
          mem_addr  <= dst_a;
          st        <= S_WR;
        end
        S_WR: begin
          mem_wr <= 1'b0;
          if (mv_left != '0) begin
            mv_left  <= mv_left - 1'b1;
            src_a    <= src_bn;
            dst_a    <= dst_bn;
            mem_addr <= src_bn;
            mem_rd   <= 1'b1;
            st       <= S_RD;
          end else if (bu_left != '0) begin
            bu_left <= bu_left - 1'b1;
            src_a   <= src_tn;
            dst_a   <= dst_tn;
            if (oneshot) begin
              mv_left  <= moves_m1;
              mem_addr <= src_tn;
              mem_rd   <= 1'b1;
              st       <= S_RD;
            end else begin
              st <= S_ARM;
            end
          end else begin
            if (inten && int_at_end) irq <= 1'b1;
            if (cont) begin
              first <= 1'b1;
              st    <= S_ARM;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dmach_pkg::*;
#(
  parameter int AW    = 16,
  parameter int NTRIG = 4,
  parameter int CW    = 16,
  parameter int SW    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic [NTRIG-1:0] trig_in,
  input  logic [31:0]      mem_rdata,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             mem_wide,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  output logic             irq,
  output logic             busy,
  output logic             trig_flag,
  output logic             ovf_flag
);

  logic          hard, rst_i;
  mode_t         mode;
  logic [CW-1:0] bsize, tsize;
  logic [SW-1:0] bstep_s, bstep_d, tstep_s, tstep_d;
  logic [AW-1:0] src_sh, dst_sh;
  logic          go, clr_trig, clr_ovf, take;

  assign hard  = cfg_we && (cfg_addr == RA_CTRL) && cfg_wdata[CTRL_HRST];
  assign rst_i = rst || hard;

  dmach_regs #(.AW(AW), .CW(CW), .SW(SW)) u_regs (
    .clk(clk), .rst(rst_i), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .mode(mode), .bsize(bsize), .tsize(tsize),
    .bstep_s(bstep_s), .bstep_d(bstep_d), .tstep_s(tstep_s), .tstep_d(tstep_d),
    .src_sh(src_sh), .dst_sh(dst_sh),
    .go(go), .clr_trig(clr_trig), .clr_ovf(clr_ovf)
  );

  dmach_trig #(.NTRIG(NTRIG)) u_trig (
    .clk(clk), .rst(rst_i), .trig_in(trig_in), .sel(mode.sel), .en(mode.trig_en),
    .take(take), .clr_trig(clr_trig), .clr_ovf(clr_ovf),
    .pend(trig_flag), .ovf(ovf_flag)
  );

  dmach_seq #(.AW(AW), .CW(CW), .SW(SW)) u_seq (
    .clk(clk), .rst(rst_i), .go(go), .pend(trig_flag),
    .inten(mode.inten), .int_at_end(mode.int_at_end), .wide(mode.wide),
    .cont(mode.cont), .oneshot(mode.oneshot),
    .bsize(bsize), .tsize(tsize),
    .bstep_s(bstep_s), .bstep_d(bstep_d), .tstep_s(tstep_s), .tstep_d(tstep_d),
    .src_sh(src_sh), .dst_sh(dst_sh), .mem_rdata(mem_rdata),
    .take(take), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .irq(irq), .busy(busy)
  );

  assign mem_wide = mode.wide;

endmodule

// File: rtl/dmach_checker.sv
module dmach_checker (
  input logic       clk,
  input logic       rst,
  input logic       cfg_we,
  input logic [2:0] cfg_addr,
  input logic [1:0] clr_bits,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       irq,
  input logic       busy,
  input logic       ovf_flag
);

  logic ovf_clear_wr;
  assign ovf_clear_wr = cfg_we && (cfg_addr == 3'd0) && (|clr_bits);

  assert_one_access_R11: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_wr_after_rd_R11: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> $past(mem_rd, 2));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_rd && !mem_wr));

  assert_irq_single_R8: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clear_wr) |=> ovf_flag);

endmodule

bind dma_chan_engine dmach_checker u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .clr_bits({cfg_wdata[3], cfg_wdata[1]}),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .irq(irq), .busy(busy), .ovf_flag(ovf_flag)
);

// File: tb/dma_chan_engine_test.sv
module dma_chan_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int NTRIG = 4;

  typedef struct packed {
    logic [15:0] bsz, tsz, bss, bsd, tss, tsd;
    logic        wide, os, cont, im, ie;
    logic [7:0]  src, dst;
  } vec_t;

  localparam int NVEC = 4;
  localparam vec_t VECS [NVEC] = '{
    '{16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h10, 8'h90},
    '{16'd5, 16'd0, 16'd2, 16'd2, 16'd0, 16'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h20, 8'hA0},
    '{16'd2, 16'd2, 16'd1, 16'hFFFF, 16'd4, 16'd8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h30, 8'hC0},
    '{16'd3, 16'd1, 16'd2, 16'd2, 16'hFFFA, 16'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h50, 8'hE0}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_we = 1'b0;
  logic [2:0]       cfg_addr = '0;
  logic [31:0]      cfg_wdata = '0;
  logic [NTRIG-1:0] trig_in = '0;
  logic [31:0]      mem_rdata;
  logic             mem_rd, mem_wr, mem_wide, irq, busy, trig_flag, ovf_flag;
  logic [15:0]      mem_addr;
  logic [31:0]      mem_wdata;

  dma_chan_engine #(.AW(16), .NTRIG(NTRIG)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .trig_in(trig_in), .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq),
    .busy(busy), .trig_flag(trig_flag), .ovf_flag(ovf_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: registered read, write at the edge
  logic [31:0] mem [256];
  initial for (int i = 0; i < 256; i++) mem[i] = (i < 128) ? (32'hA500_0000 | i) : 32'h0;
  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  // write and irq logs
  logic [15:0] wa [64];
  logic [31:0] wd [64];
  int wr_cnt = 0;
  int irq_cnt = 0;
  int irq_wr_at = -1;
  logic irq_rd_at = 1'b0;

  always @(negedge clk) begin
    if (mem_wr && wr_cnt < 64) begin
      wa[wr_cnt] = mem_addr;
      wd[wr_cnt] = mem_wdata;
      wr_cnt++;
    end
    if (irq) begin
      irq_cnt++;
      irq_wr_at = wr_cnt;
      irq_rd_at = mem_rd;
    end
  end

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic clear_log();
    wr_cnt = 0; irq_cnt = 0; irq_wr_at = -1; irq_rd_at = 1'b0;
  endtask

  task automatic cfg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic pulse(input int idx, input int wait_cyc);
    @(negedge clk);
    trig_in[idx] = 1'b1;
    @(negedge clk);
    trig_in = '0;
    repeat (wait_cyc) @(negedge clk);
  endtask

  function automatic logic [31:0] mode_word(input logic ie, im, wide, cont, os, en, input int sel);
    return {21'd0, ie, im, wide, cont, os, en, 5'(sel)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      summary();
    end
  end

  initial begin
    logic [15:0] ea [64];
    logic [15:0] es [64];
    int n, moves, ntr;
    logic [15:0] s, d;
    bit ok;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check({mem_rd, mem_wr, irq, busy, trig_flag, ovf_flag} == 6'b0, "R1 reset outputs",
          {mem_rd, mem_wr, irq, busy, trig_flag, ovf_flag}, 0);

    // table-driven transfers: R2 R3 R5 R6 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      cfg(3'd0, 32'h2);
      cfg(3'd1, mode_word(VECS[v].ie, VECS[v].im, VECS[v].wide, VECS[v].cont, VECS[v].os, 1'b1, v));
      cfg(3'd2, {16'd0, VECS[v].bsz});
      cfg(3'd3, {VECS[v].bsd, VECS[v].bss});
      cfg(3'd4, {16'd0, VECS[v].tsz});
      cfg(3'd5, {VECS[v].tsd, VECS[v].tss});
      cfg(3'd6, {24'd0, VECS[v].src});
      cfg(3'd7, {24'd0, VECS[v].dst});
      cfg(3'd0, 32'h1);
      clear_log();
      // expected write sequence
      moves = VECS[v].wide ? (int'(VECS[v].bsz) / 2 + 1) : (int'(VECS[v].bsz) + 1);
      n = 0;
      s = {8'd0, VECS[v].src};
      d = {8'd0, VECS[v].dst};
      for (int b = 0; b <= int'(VECS[v].tsz); b++) begin
        for (int m = 0; m < moves; m++) begin
          ea[n] = d; es[n] = s; n++;
          if (m < moves - 1) begin s = s + VECS[v].bss; d = d + VECS[v].bsd; end
        end
        if (b < int'(VECS[v].tsz)) begin s = s + VECS[v].tss; d = d + VECS[v].tsd; end
      end
      ntr = VECS[v].os ? 1 : int'(VECS[v].tsz) + 1;
      for (int t = 0; t < ntr; t++) pulse(v, 40);
      ok = (wr_cnt == n);
      for (int k = 0; k < n; k++)
        if (wa[k] != ea[k] || wd[k] != (32'hA500_0000 | {16'd0, es[k]})) ok = 0;
      check(ok, "R3/R5/R6 write sequence", wr_cnt, n);
      check(busy == VECS[v].cont, "R7 busy after transfer", busy, VECS[v].cont);
      if (!VECS[v].ie)
        check(irq_cnt == 0, "R8 irq disabled", irq_cnt, 0);
      else if (!VECS[v].im)
        check(irq_cnt == 1 && irq_wr_at == 0 && irq_rd_at, "R8 irq at start", irq_wr_at, 0);
      else
        check(irq_cnt == 1 && irq_wr_at == n, "R8 irq at end", irq_wr_at, n);
    end

    // R9: disabled trigger ignored
    cfg(3'd0, 32'h2);
    cfg(3'd1, mode_word(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 0));
    cfg(3'd6, 32'h10); cfg(3'd7, 32'h90); cfg(3'd0, 32'h1);
    clear_log();
    pulse(0, 20);
    check(wr_cnt == 0 && !trig_flag, "R9 disabled trigger ignored", wr_cnt, 0);
    // R9: unselected input ignored, selected one accepted
    cfg(3'd1, mode_word(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2));
    pulse(1, 20);
    check(wr_cnt == 0 && !trig_flag, "R9 other input ignored", wr_cnt, 0);
    pulse(2, 20);
    check(wr_cnt == 1 && wa[0] == 16'h90, "R9 selected input accepted", wr_cnt, 1);

    // R4: shadow reload only at transfer start, continuous re-arm (R7)
    cfg(3'd0, 32'h2);
    cfg(3'd1, mode_word(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 0));
    cfg(3'd4, 32'h1); cfg(3'd5, 32'h0001_0001);
    cfg(3'd6, 32'h10); cfg(3'd7, 32'h90); cfg(3'd0, 32'h1);
    clear_log();
    pulse(0, 20);
    cfg(3'd7, 32'hB0);
    pulse(0, 20);
    check(wr_cnt == 2 && wa[1] == 16'h91 && wd[1] == 32'hA500_0011, "R4 mid-transfer shadow unused",
          wa[1], 16'h91);
    pulse(0, 20);
    check(wr_cnt == 3 && wa[2] == 16'hB0 && wd[2] == 32'hA500_0010, "R4 shadow loaded at start",
          wa[2], 16'hB0);

    // R10: latch while stopped, overflow, clears
    cfg(3'd0, 32'h2);
    cfg(3'd1, mode_word(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 0));
    pulse(0, 1);
    check(trig_flag && !ovf_flag, "R10 pending latched", {trig_flag, ovf_flag}, 2'b10);
    pulse(0, 1);
    check(trig_flag && ovf_flag, "R10 overflow set", {trig_flag, ovf_flag}, 2'b11);
    cfg(3'd0, 32'h8);
    check(trig_flag && !ovf_flag, "R10 overflow clear only", {trig_flag, ovf_flag}, 2'b10);
    cfg(3'd0, 32'h4);
    check(!trig_flag && !ovf_flag, "R10 pending clear", {trig_flag, ovf_flag}, 2'b00);
    pulse(0, 1);
    pulse(0, 1);
    cfg(3'd0, 32'h2);
    check(!trig_flag && !ovf_flag && !busy, "R1 hard reset clears flags",
          {trig_flag, ovf_flag, busy}, 0);
    // R1: config cleared by hard reset -> trigger enable gone
    pulse(0, 1);
    check(!trig_flag, "R1 hard reset clears config", trig_flag, 0);

    done = 1;
    summary();
  end

endmodule